// File: doc/BRIEF.md
# Serial Rate Search Sequencer

This block picks the divider modulus and the oscillator band for a clock-recovery loop that must work at several serial line rates. It runs from a slow system clock that has no relation to the line rate, and it receives the loop's lock indication as a plain input. The analog parts of the loop (oscillator, equalizer, phase detector) live outside it.

In automatic mode the block owns a 3-bit rate code. It holds each code for a fixed dwell of system-clock cycles. If lock has not appeared by the end of the dwell, it moves on to the next code, wrapping after the last legal code. While lock is present the code is frozen. In manual mode the code comes from an input bus and the internal search stands still. A standard-select input picks one of two code-to-modulus tables. Under the alternate standard some codes share a modulus, and only the high band is ever used.

Top module: `rate_search_seq`

## Requirements
- R1: While `rst_n` is low and just after it rises, with `auto_mode`=1 and `std_sel`=1, `code_out` is 000, `code_oe` is 1, `div_sel` is 2 (divide by 4), `band_hi` is 1 and `code_invalid` is 0.
- R2: `code_oe` equals `auto_mode`. In automatic mode `div_sel`/`band_hi` follow `code_out` in the same cycle.
- R3: In automatic mode with `lock_in` low, the code advances by one on the DWELL_CYCLES-th consecutive rising edge without lock, and not earlier.
- R4: In automatic mode the code runs 000,001,010,011,100 and then wraps to 000. Codes 101, 110 and 111 never appear on `code_out`.
- R5: While `lock_in` is high in automatic mode the code holds. When lock drops, a fresh full dwell starts from the held code.
- R6: `div_sel` encodes the modulus as 0=÷1, 1=÷2, 2=÷4, 3=÷8, and `band_hi`=1 means the high band. With `std_sel`=1, codes 000..100 give ÷4/high, ÷2/low, ÷2/high, ÷1/low, ÷1/high.
- R7: With `std_sel`=0, codes 000..100 give ÷4/high, ÷4/high, ÷2/high, ÷2/high, ÷1/high.
- R8: In manual mode the code is taken from `code_in` and applied on the next rising edge. The search counter does not move, and on return to automatic mode the search continues from the code it held.
- R9: In manual mode code 101 gives ÷8/low with `std_sel`=1 and ÷1/high with `std_sel`=0. Code 110 gives ÷8/high under both standards.
- R10: In manual mode code 111 gives ÷1/high and sets `code_invalid`. `code_invalid` is 0 for every other code and always 0 in automatic mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_mode | input | 1 | 1 = automatic search, 0 = manual code |
| std_sel | input | 1 | Picks the code-to-modulus table |
| lock_in | input | 1 | Lock indication from the recovery loop |
| code_in | input | 3 | Rate code used in manual mode |
| code_out | output | 3 | Search counter value, driven onto the code bus when code_oe is 1 |
| code_oe | output | 1 | Code bus direction: 1 = block drives |
| div_sel | output | 2 | Divider modulus as log2 (0..3) |
| band_hi | output | 1 | Oscillator band: 1 = high, 0 = low |
| code_invalid | output | 1 | Manual code 111 was applied |

## Verification
Assertions check on every cycle that the automatic code stays in 000..100, that each step adds one or wraps from 100 to 000, that lock or manual mode freezes the counter, that the dwell timer stays in range, and that the invalid flag only appears in manual mode with the safe ÷1/high setting. Only the directed scenarios can show that the dwell length is exact, that a dwell cut short by lock restarts in full, that every table entry under both standards is correct, and that the search resumes from the held code after a stretch in manual mode.

// File: rtl/rss_pkg.sv
package rss_pkg;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] LAST_AUTO_CODE = 3'd4;

    typedef logic [CODE_W-1:0] rate_code_t;

    typedef enum logic [1:0] {
        DIV1 = 2'd0,
        DIV2 = 2'd1,
        DIV4 = 2'd2,
        DIV8 = 2'd3
    } div_t;

    typedef struct packed {
        div_t div;
        logic band_hi;
        logic invalid;
    } rate_cfg_t;

endpackage

// File: rtl/rss_dwell_timer.sv
module rss_dwell_timer #(
    parameter int DWELL_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step
);
    localparam int DW = $clog2(DWELL_CYCLES + 1);
    localparam logic [DW-1:0] LAST = DW'(DWELL_CYCLES - 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } dwell_st_t;

    dwell_st_t st_d, st_q;
    logic      at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == LAST);
        step   = 1'b0;
        if (!run) begin
            st_d.cnt = '0;
        end else if (at_end) begin
            st_d.cnt = '0;
            step     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the dwell count never passes its last value
    a_r3_dwell_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R5: an interrupted dwell restarts from zero
    a_r5_dwell_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.cnt == '0);

endmodule

// File: rtl/rss_code_counter.sv
module rss_code_counter
    import rss_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       lock_in,
    input  logic       step,
    output rate_code_t count
);
    typedef struct packed {
        rate_code_t code;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.code > LAST_AUTO_CODE) begin
            st_d.code = '0;
        end else if (auto_mode && step) begin
            if (st_q.code == LAST_AUTO_CODE) st_d.code = '0;
            else                             st_d.code = st_q.code + CODE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.code;

    // R4: only legal search codes are ever held
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.code <= LAST_AUTO_CODE);

    // R4: the last code wraps to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && step && st_q.code == LAST_AUTO_CODE) |=> st_q.code == '0);

    // R3: a step adds exactly one below the last code
    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && step && st_q.code < LAST_AUTO_CODE)
            |=> st_q.code == $past(st_q.code) + CODE_W'(1));

    // R5: lock freezes the search
    a_r5_hold_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_mode && lock_in) |=> $stable(st_q.code));

    // R8: manual mode freezes the search
    a_r8_hold_in_manual: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> $stable(st_q.code));

endmodule

// File: rtl/rss_rate_map.sv
module rss_rate_map
    import rss_pkg::*;
(
    input  logic       std_sel,
    input  rate_code_t code,
    output rate_cfg_t  cfg
);
    always_comb begin
        cfg = '{div: DIV1, band_hi: 1'b1, invalid: 1'b0};
        unique case (code)
            3'd0: cfg.div = DIV4;
            3'd1: begin
                if (std_sel) begin
                    cfg.div     = DIV2;
                    cfg.band_hi = 1'b0;
                end else begin
                    cfg.div = DIV4;
                end
            end
            3'd2: cfg.div = DIV2;
            3'd3: begin
                if (std_sel) begin
                    cfg.div     = DIV1;
                    cfg.band_hi = 1'b0;
                end else begin
                    cfg.div = DIV2;
                end
            end
            3'd4: cfg.div = DIV1;
            3'd5: begin
                if (std_sel) begin
                    cfg.div     = DIV8;
                    cfg.band_hi = 1'b0;
                end else begin
                    cfg.div = DIV1;
                end
            end
            3'd6: cfg.div = DIV8;
            default: cfg.invalid = 1'b1;
        endcase
    end

    // R10: the unused code falls back to divide-by-1 on the high band
    a_r10_safe_default: assert final (!cfg.invalid || (cfg.div == DIV1 && cfg.band_hi));

    // R7: the alternate standard uses the high band only
    a_r7_std0_high: assert final (std_sel || cfg.band_hi);

endmodule

// File: rtl/rate_search_seq.sv
module rate_search_seq
    import rss_pkg::*;
#(
    parameter int DWELL_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_mode,
    input  logic       std_sel,
    input  logic       lock_in,
    input  logic [2:0] code_in,
    output logic [2:0] code_out,
    output logic       code_oe,
    output logic [1:0] div_sel,
    output logic       band_hi,
    output logic       code_invalid
);
    typedef struct packed {
        rate_code_t man_code;
    } top_st_t;

    top_st_t    st_d, st_q;
    logic       step;
    rate_code_t search_code;
    rate_code_t active_code;
    rate_cfg_t  cfg;

    always_comb begin
        st_d          = st_q;
        st_d.man_code = code_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rss_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (auto_mode && !lock_in),
        .step  (step)
    );

    rss_code_counter u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .auto_mode (auto_mode),
        .lock_in   (lock_in),
        .step      (step),
        .count     (search_code)
    );

    assign active_code = auto_mode ? search_code : st_q.man_code;

    rss_rate_map u_map (
        .std_sel (std_sel),
        .code    (active_code),
        .cfg     (cfg)
    );

    assign code_out     = search_code;
    assign code_oe      = auto_mode;
    assign div_sel      = cfg.div;
    assign band_hi      = cfg.band_hi;
    assign code_invalid = cfg.invalid;

    // R10: the invalid flag never shows in automatic mode
    a_r10_no_invalid_auto: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mode |-> !code_invalid);

    // R4: the driven code bus never carries an unused code
    a_r4_bus_legal: assert property (@(posedge clk) disable iff (!rst_n)
        code_oe |-> code_out <= 3'd4);

endmodule

// File: tb/rate_search_seq_test.sv
module rate_search_seq_test;
    localparam int DW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b1;
    logic       std_sel = 1'b1;
    logic       lock_in = 1'b0;
    logic [2:0] code_in = 3'd0;
    logic [2:0] code_out;
    logic       code_oe;
    logic [1:0] div_sel;
    logic       band_hi;
    logic       code_invalid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rate_search_seq #(.DWELL_CYCLES(DW)) uut (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .std_sel(std_sel),
        .lock_in(lock_in), .code_in(code_in), .code_out(code_out),
        .code_oe(code_oe), .div_sel(div_sel), .band_hi(band_hi),
        .code_invalid(code_invalid)
    );

    // expected {div_sel, band_hi, invalid} from the requirement tables
    function automatic logic [3:0] exp_cfg(input logic s, input logic [2:0] c);
        case (c)
            3'd0: return {2'd2, 1'b1, 1'b0};
            3'd1: return s ? {2'd1, 1'b0, 1'b0} : {2'd2, 1'b1, 1'b0};
            3'd2: return {2'd1, 1'b1, 1'b0};
            3'd3: return s ? {2'd0, 1'b0, 1'b0} : {2'd1, 1'b1, 1'b0};
            3'd4: return {2'd0, 1'b1, 1'b0};
            3'd5: return s ? {2'd3, 1'b0, 1'b0} : {2'd0, 1'b1, 1'b0};
            3'd6: return {2'd3, 1'b1, 1'b0};
            default: return {2'd0, 1'b1, 1'b1};
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; auto_mode = 1'b1; std_sel = 1'b1; lock_in = 1'b0; code_in = 3'd0;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; auto_mode = 1'b1; std_sel = 1'b1; lock_in = 1'b0;
        tick(2);
        check("R1 code in reset", {5'd0, code_out}, 8'd0);
        check("R1 cfg in reset", {4'd0, div_sel, band_hi, code_invalid}, {4'd0, 2'd2, 1'b1, 1'b0});
        rst_n = 1'b1;
        tick(1);
        check("R1 code after reset", {5'd0, code_out}, 8'd0);
        check("R2 oe in auto", {7'd0, code_oe}, 8'd1);
    endtask

    task automatic t_auto_walk(input logic s);
        logic [2:0] exp_code;
        do_reset();
        std_sel = s;
        exp_code = 3'd0;
        #1;
        check(s ? "R6 code 0 map" : "R7 code 0 map",
              {4'd0, div_sel, band_hi, code_invalid}, {4'd0, exp_cfg(s, 3'd0)});
        for (int i = 0; i < 6; i++) begin
            tick(DW - 1);
            check("R3 no early advance", {5'd0, code_out}, {5'd0, exp_code});
            tick(1);
            exp_code = (exp_code == 3'd4) ? 3'd0 : exp_code + 3'd1;
            check("R4 code sequence", {5'd0, code_out}, {5'd0, exp_code});
            check(s ? "R6 auto map" : "R7 auto map",
                  {4'd0, div_sel, band_hi, code_invalid}, {4'd0, exp_cfg(s, exp_code)});
        end
    endtask

    task automatic t_lock_hold();
        do_reset();
        tick(DW * 2);
        check("R5 setup code", {5'd0, code_out}, 8'd2);
        tick(2);
        lock_in = 1'b1;
        tick(DW * 5);
        check("R5 hold under lock", {5'd0, code_out}, 8'd2);
        lock_in = 1'b0;
        tick(DW - 1);
        check("R5 fresh dwell after lock", {5'd0, code_out}, 8'd2);
        tick(1);
        check("R5 resume from held code", {5'd0, code_out}, 8'd3);
    endtask

    task automatic t_manual_table();
        do_reset();
        auto_mode = 1'b0;
        for (int s = 0; s < 2; s++) begin
            std_sel = s[0];
            for (int c = 0; c < 8; c++) begin
                code_in = c[2:0];
                tick(1);
                check(c == 7 ? "R10 manual 111" : (c >= 5 ? "R9 manual 8x codes" : "R8 manual map"),
                      {4'd0, div_sel, band_hi, code_invalid}, {4'd0, exp_cfg(s[0], c[2:0])});
            end
        end
        check("R2 oe in manual", {7'd0, code_oe}, 8'd0);
    endtask

    task automatic t_manual_freeze();
        do_reset();
        tick(DW);
        check("R8 setup code", {5'd0, code_out}, 8'd1);
        auto_mode = 1'b0;
        code_in = 3'd6;
        check("R8 not yet applied", {4'd0, div_sel, band_hi, code_invalid}, {4'd0, exp_cfg(1'b1, 3'd1)});
        tick(1);
        check("R8 applied next edge", {4'd0, div_sel, band_hi, code_invalid}, {4'd0, exp_cfg(1'b1, 3'd6)});
        tick(DW * 4);
        check("R8 counter frozen", {5'd0, code_out}, 8'd1);
        auto_mode = 1'b1;
        code_in = 3'd7;
        #1;
        check("R10 no invalid in auto", {7'd0, code_invalid}, 8'd0);
        check("R2 auto map follows code", {4'd0, div_sel, band_hi, code_invalid}, {4'd0, exp_cfg(1'b1, 3'd1)});
        tick(DW);
        check("R8 resume after manual", {5'd0, code_out}, 8'd2);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_auto_walk(1'b1);
        t_auto_walk(1'b0);
        t_lock_hold();
        t_manual_table();
        t_manual_freeze();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule